// File: doc/BRIEF.md
# Out-of-Order Memory Command Scoreboard

This block holds pending DRAM-style read and write commands between an upstream command queue and the issue stage of a memory controller. Each accepted command takes a free slot in a small pool. There it waits until three conditions hold: every older command it conflicts with has left, its own settling delay has run out, and the pick logic chooses it. Two commands conflict when they target the same bank, row and column and at least one of them is a write. Commands that do not conflict may leave out of arrival order. A command whose row is already open in its bank is preferred. Among commands of the same preference, the one that arrived first goes first.

Commands enter on a valid/ready stream. A command is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends only on occupancy, so the upstream side may hold `in_valid` and its fields for as long as it needs. Commands leave on a second valid/ready stream. `out_valid` is high whenever some slot is eligible, and one command is removed on each cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the command on the output may be replaced by a higher-priority one. This makes the output a per-cycle offer to the issue stage rather than a held transfer. Each slot keeps a wait counter. Once `cfg_starve_limit` is non-zero and a slot has waited that many cycles, the slot overrides the row preference.

Top module: `cmd_sb_top`

## Requirements
- R1: The pool holds up to DEPTH commands (16 by default). `in_ready` is low exactly when every slot is occupied. A command is accepted on a cycle with `in_valid` and `in_ready` both high.
- R2: A command that matches an older pending command on bank, row and column, where at least one of the two is a write, is not issued before that older command. This covers read after write, write after read and write after write.
- R3: Two reads to the same bank, row and column have no ordering between them. The younger read may issue first.
- R4: A command is not eligible until `in_delay` cycles after the clock edge that accepts it. With a delay of 0 it is eligible in the next cycle.
- R5: `out_valid` is high whenever at least one slot is eligible, and the output fields describe exactly one eligible command. On a cycle with `out_valid` and `out_ready` both high, that command is removed and its slot is freed.
- R6: The pool records the row of the last command issued to each bank. An eligible command whose bank has that row recorded is preferred over eligible commands that miss.
- R7: Among eligible commands of the same preference class, the command accepted earliest is issued first.
- R8: Each slot counts the cycles it has waited since acceptance. When `cfg_starve_limit` is non-zero and that count is at least `cfg_starve_limit`, the eligible slot takes priority over row-hit and plain slots. A limit of 0 turns this override off.
- R9: After reset the pool is empty, no bank has a recorded row, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_starve_limit | input | AGE_W | Wait count that turns a slot into an override; 0 disables the override |
| in_valid | input | 1 | Upstream command present |
| in_ready | output | 1 | A slot is free |
| in_write | input | 1 | 1 = write, 0 = read |
| in_bank | input | BANK_W | Bank of the incoming command |
| in_row | input | ROW_W | Row of the incoming command |
| in_col | input | COL_W | Column of the incoming command |
| in_delay | input | TMR_W | Cycles until the command becomes eligible |
| out_valid | output | 1 | An eligible command is offered |
| out_ready | input | 1 | The issue stage takes the offered command |
| out_write | output | 1 | Kind of the offered command |
| out_bank | output | BANK_W | Bank of the offered command |
| out_row | output | ROW_W | Row of the offered command |
| out_col | output | COL_W | Column of the offered command |

## Verification
The bench builds the pool with DEPTH=4, BANK_W=1, ROW_W=2 and COL_W=2. With these values, a full pool, every hazard pairing and every class contention can be set up in a handful of pushes, and every issue order can be worked out by hand. Commands are loaded while the output is held back. The output is then released, and the exact order and cycle of issue are compared against the order the priority rules imply. Starvation is checked by running the same load with the override off and on and comparing the two orders.

// File: rtl/cmd_sb_pkg.sv
package cmd_sb_pkg;
  typedef enum logic [1:0] {
    CLS_AGED  = 2'd0,
    CLS_ROW   = 2'd1,
    CLS_PLAIN = 2'd2,
    CLS_NONE  = 2'd3
  } pick_cls_e;
endpackage

// File: rtl/cmd_sb_slot.sv
module cmd_sb_slot #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 10,
  parameter int TMR_W  = 4,
  parameter int AGE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              in_write,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TMR_W-1:0]  in_delay,
  input  logic [DEPTH-1:0]  in_dep,
  input  logic [DEPTH-1:0]  in_elder,
  input  logic [DEPTH-1:0]  freed,
  input  logic              issue_me,
  input  logic [AGE_W-1:0]  cfg_limit,
  output logic              valid_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              starved_o,
  output logic [DEPTH-1:0]  elder_o
);
  logic              valid_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TMR_W-1:0]  timer_q;
  logic [AGE_W-1:0]  age_q;
  logic [DEPTH-1:0]  dep_q;
  logic [DEPTH-1:0]  elder_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      timer_q <= '0;
      age_q   <= '0;
      dep_q   <= '0;
      elder_q <= '0;
    end else if (alloc) begin
      valid_q <= 1'b1;
      write_q <= in_write;
      addr_q  <= in_addr;
      timer_q <= in_delay;
      age_q   <= '0;
      dep_q   <= in_dep;
      elder_q <= in_elder;
    end else begin
      if (issue_me) valid_q <= 1'b0;
      if (timer_q != '0) timer_q <= timer_q - 1'b1;
      if (valid_q && age_q != '1) age_q <= age_q + 1'b1;
      dep_q   <= dep_q & ~freed;
      elder_q <= elder_q & ~freed;
    end
  end

  assign valid_o   = valid_q;
  assign write_o   = write_q;
  assign addr_o    = addr_q;
  assign ready_o   = valid_q && (dep_q == '0) && (timer_q == '0);
  assign starved_o = valid_q && (cfg_limit != '0) && (age_q >= cfg_limit);
  assign elder_o   = elder_q;

  // R4: a pending delay counts down one per cycle and the slot stays occupied
  a_r4_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && timer_q != '0) |=> (valid_q && timer_q == $past(timer_q) - 1'b1));

  // R2: the picker never takes a slot with an outstanding hazard or delay
  a_r2_issue_clean: assert property (@(posedge clk) disable iff (!rst_n)
    issue_me |-> (valid_q && dep_q == '0 && timer_q == '0));
endmodule

// File: rtl/cmd_sb_rows.sv
module cmd_sb_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fire,
  input  logic [BANK_W-1:0]            fire_bank,
  input  logic [ROW_W-1:0]             fire_row,
  output logic [NBANK-1:0]             open_v,
  output logic [NBANK-1:0][ROW_W-1:0]  open_row
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v   <= '0;
      open_row <= '0;
    end else if (fire) begin
      open_v[fire_bank]   <= 1'b1;
      open_row[fire_bank] <= fire_row;
    end
  end

  // R6: after an issue the bank reports the issued row as open
  a_r6_row_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (open_v[$past(fire_bank)] && open_row[$past(fire_bank)] == $past(fire_row)));
endmodule

// File: rtl/cmd_sb_pick.sv
module cmd_sb_pick
  import cmd_sb_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] ready,
  input  logic [DEPTH-1:0] starved,
  input  logic [DEPTH-1:0] hit,
  input  logic [DEPTH-1:0] elder [DEPTH],
  output logic [DEPTH-1:0] grant,
  output logic             any
);
  pick_cls_e        cls;
  logic [DEPTH-1:0] cand;

  always_comb begin
    if ((ready & starved) != '0)  cls = CLS_AGED;
    else if ((ready & hit) != '0) cls = CLS_ROW;
    else if (ready != '0)         cls = CLS_PLAIN;
    else                          cls = CLS_NONE;
    case (cls)
      CLS_AGED:  cand = ready & starved;
      CLS_ROW:   cand = ready & hit;
      CLS_PLAIN: cand = ready;
      default:   cand = '0;
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_old
    assign grant[i] = cand[i] && ((elder[i] & cand) == '0);
  end

  assign any = (cls != CLS_NONE);

  // R5: exactly one grant whenever something is eligible
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ready != '0) |-> $onehot(grant));

  // R5: grants only go to eligible slots
  a_r5_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready) == '0);
endmodule

// File: rtl/cmd_sb_top.sv
module cmd_sb_top #(
  parameter int DEPTH  = 16,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int TMR_W  = 4,
  parameter int AGE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AGE_W-1:0]  cfg_starve_limit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [TMR_W-1:0]  in_delay,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col
);
  localparam int ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int NBANK  = 1 << BANK_W;

  logic [DEPTH-1:0]  valid, wr, ready, starved, hit, grant, freed, alloc_vec, match;
  logic [DEPTH-1:0]  elder [DEPTH];
  logic [ADDR_W-1:0] addr  [DEPTH];
  logic [ADDR_W-1:0] in_addr;
  logic              any, fire, accept, full;
  logic              sel_w;
  logic [ADDR_W-1:0] sel_addr;
  logic [NBANK-1:0]             open_v;
  logic [NBANK-1:0][ROW_W-1:0]  open_row;

  assign in_addr  = {in_bank, in_row, in_col};
  assign full     = &valid;
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;
  assign fire     = any && out_ready;
  assign freed    = grant & {DEPTH{fire}};

  // lowest free slot takes the next command
  always_comb begin
    logic found;
    found     = 1'b0;
    alloc_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid[i] && !found) begin
        alloc_vec[i] = accept;
        found        = 1'b1;
      end
    end
  end

  // hazard against older pending entries; read pairs never conflict
  always_comb begin
    for (int j = 0; j < DEPTH; j++)
      match[j] = valid[j] && !freed[j] && (addr[j] == in_addr) && (wr[j] || in_write);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    cmd_sb_slot #(
      .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TMR_W(TMR_W), .AGE_W(AGE_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_vec[i]),
      .in_write(in_write), .in_addr(in_addr), .in_delay(in_delay),
      .in_dep(match), .in_elder(valid & ~freed), .freed(freed),
      .issue_me(freed[i]), .cfg_limit(cfg_starve_limit),
      .valid_o(valid[i]), .write_o(wr[i]), .addr_o(addr[i]),
      .ready_o(ready[i]), .starved_o(starved[i]), .elder_o(elder[i])
    );
    assign hit[i] = open_v[addr[i][ADDR_W-1 -: BANK_W]] &&
                    (open_row[addr[i][ADDR_W-1 -: BANK_W]] == addr[i][COL_W +: ROW_W]);
  end

  cmd_sb_pick #(.DEPTH(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n),
    .ready(ready), .starved(starved), .hit(hit), .elder(elder),
    .grant(grant), .any(any)
  );

  always_comb begin
    sel_w    = 1'b0;
    sel_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        sel_w    = sel_w | wr[i];
        sel_addr = sel_addr | addr[i];
      end
    end
  end

  assign out_valid = any;
  assign out_write = sel_w;
  assign out_bank  = sel_addr[ADDR_W-1 -: BANK_W];
  assign out_row   = sel_addr[COL_W +: ROW_W];
  assign out_col   = sel_addr[COL_W-1:0];

  cmd_sb_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .fire_bank(out_bank), .fire_row(out_row),
    .open_v(open_v), .open_row(open_row)
  );

  // R1: a full pool refuses input
  a_r1_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid) == DEPTH) |-> !in_ready);

  // R1: an accepted command occupies one more slot next cycle unless one left
  a_r1_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fire) |=> ($countones(valid) == $past($countones(valid)) + 1));

  // R8: an aged eligible slot beats every other class
  a_r8_aged_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (ready & starved) != '0) |-> ((grant & starved) != '0));
endmodule

// File: tb/cmd_sb_top_tb_top.sv
module cmd_sb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int BANK_W = 1;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 2;
  localparam int TMR_W  = 4;
  localparam int AGE_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AGE_W-1:0] cfg_starve_limit = '0;
  logic in_valid = 1'b0, in_ready, in_write = 1'b0;
  logic [BANK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0]  in_row = '0;
  logic [COL_W-1:0]  in_col = '0;
  logic [TMR_W-1:0]  in_delay = '0;
  logic out_valid, out_ready = 1'b0, out_write;
  logic [BANK_W-1:0] out_bank;
  logic [ROW_W-1:0]  out_row;
  logic [COL_W-1:0]  out_col;

  int n_chk = 0, n_fail = 0, cyc = 0, nlog = 0, rel = 0;
  logic [5:0] log_id [16];
  int         log_cyc [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_sb_top #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .TMR_W(TMR_W), .AGE_W(AGE_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_starve_limit(cfg_starve_limit),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_bank(in_bank), .in_row(in_row), .in_col(in_col), .in_delay(in_delay),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_bank(out_bank), .out_row(out_row), .out_col(out_col)
  );

  // command id: {write, bank, row[1:0], col[1:0]}
  function automatic logic [5:0] mk(input logic w, input int b, input int r, input int c);
    return {w, b[0], r[1:0], c[1:0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nlog = 0;
  endtask

  task automatic push(input logic w, input int b, input int r, input int c, input int d);
    @(negedge clk);
    in_valid = 1'b1; in_write = w;
    in_bank = b[BANK_W-1:0]; in_row = r[ROW_W-1:0]; in_col = c[COL_W-1:0];
    in_delay = d[TMR_W-1:0];
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    out_ready = 1'b1;
    rel = cyc;
    for (int k = 0; k < n; k++) begin
      if (out_valid && nlog < 16) begin
        log_id[nlog]  = {out_write, out_bank, out_row, out_col};
        log_cyc[nlog] = cyc - rel;
        nlog++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic chk_order(input string tag, input int n,
                           input logic [5:0] e0, input logic [5:0] e1,
                           input logic [5:0] e2, input logic [5:0] e3);
    logic [5:0] e [4];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(nlog == n, {tag, " count"}, nlog, n);
    for (int k = 0; k < n && k < nlog; k++)
      chk(log_id[k] == e[k], {tag, " order"}, log_id[k], e[k]);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    // R9 reset state
    do_reset();
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);

    // R1 fill to capacity, R7 oldest-first with no row hits
    push(0, 0, 0, 0, 0); push(0, 1, 1, 0, 0); push(0, 0, 2, 1, 0); push(0, 1, 3, 1, 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 full stall", in_ready, 0);
    drain(1);
    chk(in_ready == 1'b1, "R1 slot freed", in_ready, 1);
    drain(10);
    chk_order("R7 oldest", 4, mk(0,0,0,0), mk(0,1,1,0), mk(0,0,2,1), mk(0,1,3,1));

    // R6 row hit preferred within one bank
    do_reset();
    push(0, 0, 1, 0, 0); push(0, 0, 2, 0, 0); push(0, 0, 1, 1, 0); push(0, 1, 3, 0, 0);
    drain(10);
    chk_order("R6 row hit", 4, mk(0,0,1,0), mk(0,0,1,1), mk(0,0,2,0), mk(0,1,3,0));

    // R2 read after write, R4 delay holds the write back
    do_reset();
    push(1, 0, 1, 0, 12); push(0, 0, 1, 0, 0); push(0, 1, 0, 0, 0);
    drain(30);
    chk_order("R2 raw", 3, mk(0,1,0,0), mk(1,0,1,0), mk(0,0,1,0), 6'd0);
    chk(log_cyc[0] <= 1, "R4 zero delay issue cycle", log_cyc[0], 0);
    chk(log_cyc[1] >= 8, "R4 delayed write issue cycle", log_cyc[1], 8);

    // R2 write after read
    do_reset();
    push(0, 0, 1, 0, 12); push(1, 0, 1, 0, 0); push(0, 1, 0, 0, 0);
    drain(30);
    chk_order("R2 war", 3, mk(0,1,0,0), mk(0,0,1,0), mk(1,0,1,0), 6'd0);

    // R3 two reads to one address: the younger goes early
    do_reset();
    push(0, 0, 1, 0, 12); push(0, 0, 1, 0, 0);
    drain(30);
    chk(nlog == 2, "R3 rar count", nlog, 2);
    chk(log_cyc[0] <= 1, "R3 rar younger early", log_cyc[0], 0);

    // R2 write after write: the younger waits for the delayed older
    do_reset();
    push(1, 0, 1, 0, 12); push(1, 0, 1, 0, 0);
    drain(30);
    chk(nlog == 2, "R2 waw count", nlog, 2);
    chk(log_cyc[0] >= 8, "R2 waw younger held", log_cyc[0], 8);

    // R6 hits beat an older miss while the override is off
    do_reset();
    cfg_starve_limit = '0;
    push(0, 1, 1, 0, 0);
    drain(4);
    nlog = 0;
    push(0, 0, 0, 0, 0); push(0, 1, 1, 1, 0); push(0, 1, 1, 2, 0);
    repeat (3) @(negedge clk);
    drain(10);
    chk_order("R6 hit over older", 3, mk(0,1,1,1), mk(0,1,1,2), mk(0,0,0,0), 6'd0);

    // R8 same load with the override on: aged slots go oldest-first
    do_reset();
    cfg_starve_limit = 6'd1;
    push(0, 1, 1, 0, 0);
    drain(4);
    nlog = 0;
    push(0, 0, 0, 0, 0); push(0, 1, 1, 1, 0); push(0, 1, 1, 2, 0);
    repeat (3) @(negedge clk);
    drain(10);
    chk_order("R8 starve override", 3, mk(0,0,0,0), mk(0,1,1,1), mk(0,1,1,2), 6'd0);
    cfg_starve_limit = '0;

    @(negedge clk);
    chk(out_valid == 1'b0, "R5 empty after drain", out_valid, 0);
    report();
  end
endmodule